// File: doc/BRIEF.md
# Metropolis Acceptance Unit

This unit makes the accept/reject call of one random-walk Metropolis step in a sampler that fits a piecewise signal model. A caller presents a candidate parameter value together with its kind. For a change-point candidate it also presents the two neighbouring change points. The unit checks the ordering first. A candidate that breaks the ordering is refused at once, and no likelihood request is made for it. Any other candidate raises a request to an external likelihood engine. That engine answers with the candidate's summed log-likelihood over the data window and a log-prior difference.

All arithmetic stays in the fixed-point log domain. The unit keeps the log-likelihood sum of the last accepted state, so only the candidate's sum has to be produced on each iteration. Instead of raising a ratio to an exponential, it adds the saturated log-sum difference to the log-prior difference. It then compares that total with zero, and otherwise with ln(U), where U comes from an internal 16-bit LFSR through a computed logarithm table. When a candidate is accepted, the stored sum and the accepted parameter value are replaced. A precision-type candidate tells the engine that the model mean need not be rebuilt.

Top module: `metro_accept_unit`

## Requirements
- R1: After a synchronous reset, `ready`=1, `likReq`=0, `decValid`=0, `decAccept`=0, `acceptedValue`=0, `storedSum` holds the most negative W-bit value, and the LFSR holds the seed 16'hACE1.
- R2: A start in the ready state with `paramKind`=2'b01 (change point) whose `candValue` does not satisfy `lowBound` < `candValue` < `highBound` (unsigned) gives `decValid`=1 with `decAccept`=0 in the next cycle. It raises no `likReq` and leaves `storedSum`, `acceptedValue` and the LFSR unchanged.
- R3: Any other start in the ready state raises `likReq` from the next cycle until `likValid` is sampled. During that time `likRecalcMean`=1 unless the latched kind is 2'b10 (precision), for which it is 0.
- R4: On `likValid` while waiting, total = sat(sat(`candLogSum` − `storedSum`) + `logPriorDiff`), with each step clamped to the signed W-bit range. A total ≥ 0 is accepted unconditionally.
- R5: A negative total is accepted only if total ≥ lnU. lnU is found from idx = LFSR[15:8] as follows: v = 2·idx+1, p = floor(log2 v), lg = (p−9)·2^F + floor((v−2^p)·2^F / 2^p), lnU = −floor(−lg·45426 / 65536), with F = FRAC.
- R6: The LFSR shifts left and inserts bit15^bit13^bit12^bit10. It advances exactly once per likelihood decision, after its value has been used, and at no other time.
- R7: On acceptance `storedSum` takes `candLogSum` and `acceptedValue` takes the latched candidate value. On rejection both hold their values.
- R8: Overflow never flips a decision. A candidate sum at least the stored sum together with a non-negative prior difference is always accepted, including the first candidate after reset.
- R9: `start` is ignored while waiting for the likelihood result, and `likValid` is ignored while ready.
- R10: Each decision appears as a `decValid` pulse of one cycle, in the cycle after the edge that sampled the deciding input, with `decAccept` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Present a new candidate |
| paramKind | input | 2 | 00 amplitude/offset, 01 change point, 10 precision, 11 other |
| candValue | input | VW | Candidate parameter value |
| lowBound | input | VW | Lower neighbouring change point |
| highBound | input | VW | Upper neighbouring change point |
| ready | output | 1 | Unit can take a start |
| likReq | output | 1 | Likelihood result requested |
| likRecalcMean | output | 1 | Engine must rebuild the model mean |
| likValid | input | 1 | Likelihood result present |
| candLogSum | input | W | Candidate summed log-likelihood (signed, FRAC fraction bits) |
| logPriorDiff | input | W | Log-prior difference, candidate minus current (signed) |
| decValid | output | 1 | Decision pulse |
| decAccept | output | 1 | Candidate accepted |
| acceptedValue | output | VW | Last accepted parameter value |
| storedSum | output | W | Log-likelihood sum of the accepted state |

## Verification
The assertions take for granted that `likValid` is only meaningful while `likReq` is high, and that the likelihood inputs are stable on the edge that samples `likValid`. The stimulus drives every input half a cycle away from the sampling edge. It holds the likelihood inputs stable for the whole cycle in which `likValid` is high. Stray starts and stray `likValid` pulses fall only in phases where the unit must ignore them. Candidate sums are drawn close to the stored sum, so that the ln(U) comparison decides often, and occasionally at the extremes of the range to exercise saturation.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    KIND_AMP    = 2'd0,
    KIND_CHANGE = 2'd1,
    KIND_PREC   = 2'd2,
    KIND_OTHER  = 2'd3
  } param_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCand;
    logic orderReject;
    logic decide;
  } ctrl_strobe_t;

  localparam int RNG_W    = 16;
  localparam int IDX_W    = 8;
  localparam int LN2_Q16  = 45426;
  localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         likValid,
  input  logic         orderOk,
  output ctrl_strobe_t strobe,
  output logic         ready,
  output logic         waiting
);

  ctrl_state_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (orderOk) begin
            strobe.latchCand = 1'b1;
            stateNext        = ST_WAIT;
          end else begin
            strobe.orderReject = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (likValid) begin
          strobe.decide = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign ready   = (state == ST_IDLE);
  assign waiting = (state == ST_WAIT);

  // R9
  wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !likValid) |=> waiting);

endmodule

// File: rtl/mau_dpath.sv
module mau_dpath
  import mau_pkg::*;
#(
  parameter int W    = 24,
  parameter int VW   = 12,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_strobe_t  strobe,
  input  logic [1:0]    paramKind,
  input  logic [VW-1:0] candValue,
  input  logic [VW-1:0] lowBound,
  input  logic [VW-1:0] highBound,
  input  logic [W-1:0]  candLogSum,
  input  logic [W-1:0]  logPriorDiff,
  output logic          orderOk,
  output logic          recalcMean,
  output logic          decValid,
  output logic          decAccept,
  output logic [VW-1:0] acceptedValue,
  output logic [W-1:0]  storedSum
);

  localparam logic [W-1:0] SUM_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SUM_MAX = {1'b0, {(W-1){1'b1}}};
  localparam int IDX_LO = RNG_W - IDX_W;
  localparam int LOG_BITS = IDX_W + 1;

  logic [VW-1:0]    candReg;
  param_kind_e      kindReg;
  logic [RNG_W-1:0] lfsr;
  logic [RNG_W-1:0] lfsrNext;
  logic [W:0]       diffWide, totalWide;
  logic [W-1:0]     diffSat, totalSat, lnUW;
  logic             acceptNow;

  function automatic logic [W-1:0] clampSum(input logic [W:0] x);
    if (x[W] != x[W-1]) return x[W] ? SUM_MIN : SUM_MAX;
    return x[W-1:0];
  endfunction

  // ln of a uniform draw in fixed point, from the table index
  function automatic int lnUniform(input logic [IDX_W-1:0] idx);
    int v, p, lg, mag;
    v = 2 * int'(idx) + 1;
    p = 0;
    for (int b = 0; b < LOG_BITS; b++)
      if (v >= (1 << b)) p = b;
    lg  = (p - LOG_BITS) * (1 << FRAC) + ((v - (1 << p)) * (1 << FRAC)) / (1 << p);
    mag = -lg;
    return -((mag * LN2_Q16) >>> 16);
  endfunction

  assign orderOk = (param_kind_e'(paramKind) != KIND_CHANGE) ||
                   ((lowBound < candValue) && (candValue < highBound));

  assign recalcMean = (kindReg != KIND_PREC);

  assign diffWide  = {candLogSum[W-1], candLogSum} - {storedSum[W-1], storedSum};
  assign diffSat   = clampSum(diffWide);
  assign totalWide = {diffSat[W-1], diffSat} + {logPriorDiff[W-1], logPriorDiff};
  assign totalSat  = clampSum(totalWide);
  assign lnUW      = W'(lnUniform(lfsr[RNG_W-1:IDX_LO]));

  assign acceptNow = !totalSat[W-1] || ($signed(totalSat) >= $signed(lnUW));

  assign lfsrNext = {lfsr[RNG_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_ff @(posedge clk) begin
    if (rst) begin
      candReg       <= '0;
      kindReg       <= KIND_AMP;
      lfsr          <= RNG_SEED;
      storedSum     <= SUM_MIN;
      acceptedValue <= '0;
      decValid      <= 1'b0;
      decAccept     <= 1'b0;
    end else begin
      decValid  <= strobe.orderReject | strobe.decide;
      decAccept <= strobe.decide & acceptNow;
      if (strobe.latchCand) begin
        candReg <= candValue;
        kindReg <= param_kind_e'(paramKind);
      end
      if (strobe.decide) begin
        lfsr <= lfsrNext;
        if (acceptNow) begin
          storedSum     <= candLogSum;
          acceptedValue <= candReg;
        end
      end
    end
  end

  // R7
  sum_update_chk: assert property (@(posedge clk) disable iff (rst)
    (storedSum != $past(storedSum)) |-> ($past(strobe.decide) && decAccept));

  // R7
  value_update_chk: assert property (@(posedge clk) disable iff (rst)
    (acceptedValue != $past(acceptedValue)) |-> ($past(strobe.decide) && decAccept));

  // R6
  lfsr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lfsr != $past(lfsr)) |-> $past(strobe.decide));

endmodule

// File: rtl/metro_accept_unit.sv
module metro_accept_unit
  import mau_pkg::*;
#(
  parameter int W    = 24,
  parameter int VW   = 12,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    paramKind,
  input  logic [VW-1:0] candValue,
  input  logic [VW-1:0] lowBound,
  input  logic [VW-1:0] highBound,
  output logic          ready,
  output logic          likReq,
  output logic          likRecalcMean,
  input  logic          likValid,
  input  logic [W-1:0]  candLogSum,
  input  logic [W-1:0]  logPriorDiff,
  output logic          decValid,
  output logic          decAccept,
  output logic [VW-1:0] acceptedValue,
  output logic [W-1:0]  storedSum
);

  ctrl_strobe_t strobe;
  logic orderOk, recalcMean, waiting;

  mau_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .likValid(likValid),
    .orderOk(orderOk), .strobe(strobe), .ready(ready), .waiting(waiting)
  );

  mau_dpath #(.W(W), .VW(VW), .FRAC(FRAC)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .paramKind(paramKind), .candValue(candValue),
    .lowBound(lowBound), .highBound(highBound),
    .candLogSum(candLogSum), .logPriorDiff(logPriorDiff),
    .orderOk(orderOk), .recalcMean(recalcMean),
    .decValid(decValid), .decAccept(decAccept),
    .acceptedValue(acceptedValue), .storedSum(storedSum)
  );

  assign likReq        = waiting;
  assign likRecalcMean = waiting && recalcMean;

  // R2
  order_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start && paramKind == 2'b01 &&
     !((lowBound < candValue) && (candValue < highBound)))
    |=> (decValid && !decAccept && !likReq));

  // R8
  no_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (likReq && likValid && ($signed(candLogSum) >= $signed(storedSum)) &&
     !logPriorDiff[W-1]) |=> (decValid && decAccept));

  // R10
  decide_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (likReq && likValid) |=> (decValid && ready));

endmodule

// File: tb/metro_accept_unit_tb.sv
module metro_accept_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 24, VW = 12, FRAC = 8;
  localparam longint SMIN = -(64'sd1 <<< (W-1));
  localparam longint SMAX = (64'sd1 <<< (W-1)) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, likValid = 1'b0;
  logic [1:0] paramKind = 2'd0;
  logic [VW-1:0] candValue = '0, lowBound = '0, highBound = '0;
  logic [W-1:0] candLogSum = '0, logPriorDiff = '0;
  logic ready, likReq, likRecalcMean, decValid, decAccept;
  logic [VW-1:0] acceptedValue;
  logic [W-1:0] storedSum;

  int nChecks = 0, nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  metro_accept_unit #(.W(W), .VW(VW), .FRAC(FRAC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .paramKind(paramKind),
    .candValue(candValue), .lowBound(lowBound), .highBound(highBound),
    .ready(ready), .likReq(likReq), .likRecalcMean(likRecalcMean),
    .likValid(likValid), .candLogSum(candLogSum), .logPriorDiff(logPriorDiff),
    .decValid(decValid), .decAccept(decAccept),
    .acceptedValue(acceptedValue), .storedSum(storedSum)
  );

  // ---------------- behavioural reference ----------------
  bit     mWait = 0, mDecV = 0, mDecA = 0, modelLive = 0;
  longint mStored = SMIN;
  int     mAccVal = 0, mLfsr = 16'hACE1, latVal = 0, latKind = 0;

  function automatic longint clampL(longint x);
    if (x > SMAX) return SMAX;
    if (x < SMIN) return SMIN;
    return x;
  endfunction

  function automatic longint lnRef(int idx);
    int v, p, lg;
    v = 2 * idx + 1;
    p = 0;
    while ((v >> (p + 1)) != 0) p++;
    lg = (p - 9) * 256 + ((v - (1 << p)) * 256) / (1 << p);
    return -(((-lg) * 45426) / 65536);
  endfunction

  function automatic bit orderBad(int kind, int v, int lo, int hi);
    return (kind == 1) && !((lo < v) && (v < hi));
  endfunction

  always @(posedge clk) begin
    modelLive <= 1'b1;
    if (rst) begin
      mWait = 0; mDecV = 0; mDecA = 0; mStored = SMIN; mAccVal = 0;
      mLfsr = 16'hACE1; latVal = 0; latKind = 0;
    end else begin
      mDecV = 0; mDecA = 0;
      if (!mWait && start) begin
        if (orderBad(int'(paramKind), int'(candValue), int'(lowBound), int'(highBound))) begin
          mDecV = 1;
        end else begin
          latVal = int'(candValue); latKind = int'(paramKind); mWait = 1;
        end
      end else if (mWait && likValid) begin
        longint tot;
        bit acc;
        tot = clampL(clampL(longint'($signed(candLogSum)) - mStored) +
                     longint'($signed(logPriorDiff)));
        acc = (tot >= 0) || (tot >= lnRef((mLfsr >> 8) & 255));
        mDecV = 1; mDecA = acc;
        if (acc) begin mStored = longint'($signed(candLogSum)); mAccVal = latVal; end
        mLfsr = ((mLfsr << 1) & 16'hFFFF) |
                (((mLfsr >> 15) ^ (mLfsr >> 13) ^ (mLfsr >> 12) ^ (mLfsr >> 10)) & 1);
        mWait = 0;
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelLive && !rst) begin
      check("R9",  "ready",         ready,         !mWait);
      check("R3",  "likReq",        likReq,        mWait);
      check("R3",  "likRecalcMean", likRecalcMean, mWait && (latKind != 2));
      check("R10", "decValid",      decValid,      mDecV);
      check("R4",  "decAccept",     decAccept,     mDecA);
      check("R7",  "acceptedValue", acceptedValue, mAccVal);
      check("R7",  "storedSum",     $signed(storedSum), mStored);
    end
  end

  // ---------------- stimulus ----------------
  task automatic runCand(int kind, int v, int lo, int hi, longint sum, longint prior,
                         int lat, bit stray);
    @(negedge clk);
    start = 1; paramKind = kind[1:0]; candValue = v[VW-1:0];
    lowBound = lo[VW-1:0]; highBound = hi[VW-1:0];
    @(negedge clk);
    start = 0;
    if (orderBad(kind, v, lo, hi)) return;
    for (int i = 0; i < lat; i++) begin
      candLogSum = W'($urandom); logPriorDiff = W'($urandom);
      start = stray;          // R9: ignored while waiting
      candValue = VW'($urandom);
      @(negedge clk);
      start = 0;
    end
    likValid = 1; candLogSum = sum[W-1:0]; logPriorDiff = prior[W-1:0];
    @(negedge clk);
    likValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", ready, 1);
    check("R1", "likReq", likReq, 0);
    check("R1", "decValid", decValid, 0);
    check("R1", "storedSum", $signed(storedSum), SMIN);
    check("R1", "acceptedValue", acceptedValue, 0);

    // R9: stray likValid while ready
    likValid = 1; @(negedge clk); likValid = 0;
    check("R9", "ready after stray likValid", ready, 1);

    // R2: ordering violations at both edges
    runCand(1, 100, 100, 200, 0, 0, 0, 0);
    check("R2", "decValid", decValid, 1);
    check("R2", "decAccept", decAccept, 0);
    check("R2", "likReq", likReq, 0);
    runCand(1, 200, 100, 200, 0, 0, 0, 0);
    check("R2", "decAccept hi edge", decAccept, 0);
    check("R6", "storedSum untouched", $signed(storedSum), SMIN);

    // R8: first candidate at the floor is accepted
    runCand(1, 101, 100, 200, SMIN, 0, 1, 0);
    check("R8", "first accept", decAccept, 1);
    check("R7", "acceptedValue", acceptedValue, 101);

    // R8: huge jump upward with negative prior still accepted
    runCand(0, 7, 0, 0, SMAX, -5000, 2, 1);
    check("R8", "saturated accept", decAccept, 1);
    check("R7", "storedSum max", $signed(storedSum), SMAX);

    // R8: drop to floor is rejected
    runCand(2, 9, 0, 0, SMIN, -1, 1, 0);
    check("R8", "saturated reject", decAccept, 0);
    check("R7", "value held", acceptedValue, 7);

    // R3: precision kind does not request mean rebuild
    runCand(2, 11, 0, 0, SMAX, 0, 0, 0);
    check("R4", "equal sum accepted", decAccept, 1);

    // R5/R6: random walk near the stored sum
    for (int n = 0; n < 400; n++) begin
      int kind, lo, hi, v;
      longint sum, prior;
      kind = $urandom_range(0, 3);
      lo = $urandom_range(0, 2000); hi = lo + $urandom_range(0, 6);
      v = lo + $urandom_range(0, 7);
      sum = mStored + $urandom_range(0, 1400) - 1300;
      prior = longint'($urandom_range(0, 400)) - 250;
      if ((n % 37) == 0) sum = SMIN + $urandom_range(0, 50);
      if ((n % 53) == 0) sum = SMAX - $urandom_range(0, 50);
      runCand(kind, v, lo, hi, clampL(sum), prior, $urandom_range(0, 3), n[0]);
      if (decValid && !orderBad(kind, v, lo, hi))
        check("R5", "random decision", decAccept, mDecA);
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule